// File: doc/BRIEF.md
# CAN Frame Acceptance Filter

This block decides whether a parsed incoming CAN frame is kept or dropped. Configuration comes in as four code bytes and four mask bytes. A mask bit of 1 makes the matching code bit a don't-care, and a mask bit of 0 requires the frame bit to equal the code bit. The frame arrives as separate fields: identifier, extended flag, remote flag, length code and the first two data bytes. A one-cycle strobe marks a new frame.

A mode input chooses between two layouts. In single layout all four byte pairs form one long filter. For standard frames, that filter also reaches into the first two data bytes. In dual layout two shorter filters, A and B, are evaluated side by side, and a hit on either one keeps the frame. For standard frames, filter A additionally checks data byte 0. Its expected value and mask are assembled from the low nibbles of byte 1 and byte 3. The decision is registered and appears one clock after the strobe, together with a valid flag.

Top module: `can_accept_filter`

## Requirements
- R1: `single_mode` = 1 selects the single-filter layout and `single_mode` = 0 selects the dual-filter layout, so one frame under one configuration can be kept in one layout and dropped in the other.
- R2: Single layout, extended frame (`frm_ext` = 1): the 29-bit identifier must match {C0, C1, C2, C3[7:3]} under {M0, M1, M2, M3[7:3]}. The remote flag must equal C3[2] unless M3[2] = 1. The data bytes are not examined. Byte k of `acc_code`/`acc_mask` sits at bits [8k+7:8k].
- R3: Single layout, standard frame: identifier bits [10:0] must match {C0, C1[7:5]} under {M0, M1[7:5]}, and the remote flag must equal C1[4] unless M1[4] = 1.
- R4: Single layout, standard frame, after R3 holds: a remote frame or a length code of 0 is kept. Otherwise data byte 0 must match C2 under M2. A length code of 1 is then kept. Any longer frame also needs data byte 1 to match C3 under M3.
- R5: Dual layout, extended frame: filter A compares identifier bits [28:13] with {C0, C1} under {M0, M1}, and filter B does the same with {C2, C3} under {M2, M3}. Identifier bits [12:0] and the remote flag have no effect. The frame is kept if either filter hits.
- R6: Dual layout, standard frame: filter A matches identifier [10:0] against {C0, C1[7:5]} and remote against C1[4], masked by M0/M1. Filter B does the same with C2/C3 and M2/M3. The frame is kept if either filter hits.
- R7: Dual layout, standard frame: filter A hits only if data byte 0 also matches {C1[3:0], C3[3:0]} under {M1[3:0], M3[3:0]}. This check applies whatever the length code.
- R8: `acc_valid` is high exactly in the cycle after a cycle with `frm_valid` high. `acc_ok` carries the decision for that frame and is low whenever `acc_valid` is low.
- R9: With all mask bytes 0xFF, every frame is kept in both layouts.
- R10: While `rst_n` is low, `acc_valid` and `acc_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_valid | input | 1 | Frame fields are valid this cycle |
| frm_ext | input | 1 | 1 = 29-bit identifier, 0 = 11-bit identifier in bits [10:0] |
| frm_rtr | input | 1 | Remote frame flag |
| frm_id | input | 29 | Frame identifier |
| frm_dlc | input | 4 | Length code |
| frm_d0 | input | 8 | Data byte 0 |
| frm_d1 | input | 8 | Data byte 1 |
| acc_code | input | 32 | Code bytes C0..C3, byte k at [8k+7:8k] |
| acc_mask | input | 32 | Mask bytes M0..M3, 1 = don't care |
| single_mode | input | 1 | 1 = single layout, 0 = dual layout |
| acc_valid | output | 1 | Decision valid, one cycle after `frm_valid` |
| acc_ok | output | 1 | Frame is kept |

## Verification
In dual layout, filters A and B judge the same frame in the same cycle. The bench sets up configurations where only A hits, only B hits, both hit or neither hits, and expects the OR of the two. A second collision is between a decision leaving the output register and the next frame entering it. Strobes are applied back to back, with varying fields in every cycle. A behavioural model is compared against both outputs on every clock, so any decision that leaks into the neighbouring cycle is seen as a miscompare.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
   typedef enum logic {
      FILT_DUAL   = 1'b0,
      FILT_SINGLE = 1'b1
   } filt_mode_e;

   typedef struct packed {
      logic id_hit;
      logic rtr_hit;
      logic data_hit;
   } lane_hit_t;
endpackage

// File: rtl/can_filt_cmp.sv
module can_filt_cmp #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] val,
   input  logic [W-1:0] expv,
   input  logic [W-1:0] dc,
   output logic         hit
);
   // a bit passes if it equals the expected bit or is a don't-care
   assign hit = &(~(val ^ expv) | dc);
endmodule

// File: rtl/can_filt_single.sv
module can_filt_single #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned NBYTES = 4,
   parameter int unsigned ID_W   = 29,
   parameter int unsigned SID_W  = 11,
   parameter int unsigned DLC_W  = 4
) (
   input  logic                     ext,
   input  logic                     rtr,
   input  logic [ID_W-1:0]          id,
   input  logic [DLC_W-1:0]         dlc,
   input  logic [BYTE_W-1:0]        d0,
   input  logic [BYTE_W-1:0]        d1,
   input  logic [NBYTES*BYTE_W-1:0] code,
   input  logic [NBYTES*BYTE_W-1:0] mask,
   output logic                     hit
);
   import can_filt_pkg::*;

   localparam int unsigned TAIL_W  = ID_W - 3*BYTE_W;    // id bits held in byte 3
   localparam int unsigned ERTR_B  = BYTE_W - TAIL_W - 1; // remote bit in byte 3
   localparam int unsigned SLO_W   = SID_W - BYTE_W;     // id bits held in byte 1
   localparam int unsigned SRTR_B  = BYTE_W - SLO_W - 1;  // remote bit in byte 1
   localparam int unsigned SPARE_W = ERTR_B;             // unused low bits of byte 3

   logic [BYTE_W-1:0] cb [NBYTES];
   logic [BYTE_W-1:0] mb [NBYTES];

   for (genvar k = 0; k < NBYTES; k++) begin : g_bytes
      assign cb[k] = code[k*BYTE_W +: BYTE_W];
      assign mb[k] = mask[k*BYTE_W +: BYTE_W];
   end

   logic [ID_W-1:0]  e_exp, e_dc;
   logic [SID_W-1:0] s_exp, s_dc;
   assign e_exp = {cb[0], cb[1], cb[2], cb[3][BYTE_W-1 -: TAIL_W]};
   assign e_dc  = {mb[0], mb[1], mb[2], mb[3][BYTE_W-1 -: TAIL_W]};
   assign s_exp = {cb[0], cb[1][BYTE_W-1 -: SLO_W]};
   assign s_dc  = {mb[0], mb[1][BYTE_W-1 -: SLO_W]};

   lane_hit_t e_res, s_res;
   logic      d1_hit;

   can_filt_cmp #(.W(ID_W)) u_eid (
      .val(id), .expv(e_exp), .dc(e_dc), .hit(e_res.id_hit));
   can_filt_cmp #(.W(SID_W)) u_sid (
      .val(id[SID_W-1:0]), .expv(s_exp), .dc(s_dc), .hit(s_res.id_hit));
   can_filt_cmp #(.W(BYTE_W)) u_d0 (
      .val(d0), .expv(cb[2]), .dc(mb[2]), .hit(s_res.data_hit));
   can_filt_cmp #(.W(BYTE_W)) u_d1 (
      .val(d1), .expv(cb[3]), .dc(mb[3]), .hit(d1_hit));

   assign e_res.rtr_hit  = mb[3][ERTR_B] | (rtr == cb[3][ERTR_B]);
   assign e_res.data_hit = 1'b1;
   assign s_res.rtr_hit  = mb[1][SRTR_B] | (rtr == cb[1][SRTR_B]);

   logic short_ok, data_ok;
   assign short_ok = rtr | (dlc == '0);
   assign data_ok  = short_ok | (s_res.data_hit & ((dlc == DLC_W'(1)) | d1_hit));

   assign hit = ext ? (e_res.id_hit & e_res.rtr_hit & e_res.data_hit)
                    : (s_res.id_hit & s_res.rtr_hit & data_ok);

   logic unused_spare;
   assign unused_spare = ^{cb[3][SPARE_W-1:0], mb[3][SPARE_W-1:0]};
endmodule

// File: rtl/can_filt_dual.sv
module can_filt_dual #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned NBYTES = 4,
   parameter int unsigned ID_W   = 29,
   parameter int unsigned SID_W  = 11
) (
   input  logic                     ext,
   input  logic                     rtr,
   input  logic [ID_W-1:0]          id,
   input  logic [BYTE_W-1:0]        d0,
   input  logic [NBYTES*BYTE_W-1:0] code,
   input  logic [NBYTES*BYTE_W-1:0] mask,
   output logic                     hit
);
   import can_filt_pkg::*;

   localparam int unsigned LANES  = NBYTES / 2;
   localparam int unsigned HI_W   = 2 * BYTE_W;           // extended id bits compared
   localparam int unsigned SLO_W  = SID_W - BYTE_W;
   localparam int unsigned SRTR_B = BYTE_W - SLO_W - 1;
   localparam int unsigned NIB    = BYTE_W / 2;
   localparam int unsigned GAP_W  = ID_W - HI_W - SID_W;  // id bits no lane reads

   logic [BYTE_W-1:0] cb [NBYTES];
   logic [BYTE_W-1:0] mb [NBYTES];
   logic [LANES-1:0]  lane_hit;

   for (genvar k = 0; k < NBYTES; k++) begin : g_bytes
      assign cb[k] = code[k*BYTE_W +: BYTE_W];
      assign mb[k] = mask[k*BYTE_W +: BYTE_W];
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      lane_hit_t e_res, s_res;

      can_filt_cmp #(.W(HI_W)) u_eid (
         .val(id[ID_W-1 -: HI_W]),
         .expv({cb[2*g], cb[2*g+1]}),
         .dc({mb[2*g], mb[2*g+1]}),
         .hit(e_res.id_hit));
      can_filt_cmp #(.W(SID_W)) u_sid (
         .val(id[SID_W-1:0]),
         .expv({cb[2*g], cb[2*g+1][BYTE_W-1 -: SLO_W]}),
         .dc({mb[2*g], mb[2*g+1][BYTE_W-1 -: SLO_W]}),
         .hit(s_res.id_hit));

      assign e_res.rtr_hit  = 1'b1;
      assign e_res.data_hit = 1'b1;
      assign s_res.rtr_hit  = mb[2*g+1][SRTR_B] | (rtr == cb[2*g+1][SRTR_B]);

      if (g == 0) begin : g_data
         can_filt_cmp #(.W(BYTE_W)) u_d0 (
            .val(d0),
            .expv({cb[1][NIB-1:0], cb[3][NIB-1:0]}),
            .dc({mb[1][NIB-1:0], mb[3][NIB-1:0]}),
            .hit(s_res.data_hit));
      end else begin : g_nodata
         assign s_res.data_hit = 1'b1;
      end

      assign lane_hit[g] = ext ? (e_res.id_hit & e_res.rtr_hit & e_res.data_hit)
                               : (s_res.id_hit & s_res.rtr_hit & s_res.data_hit);
   end

   assign hit = |lane_hit;

   logic unused_gap;
   assign unused_gap = ^id[SID_W +: GAP_W];
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned NBYTES = 4,
   parameter int unsigned ID_W   = 29,
   parameter int unsigned SID_W  = 11,
   parameter int unsigned DLC_W  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     frm_valid,
   input  logic                     frm_ext,
   input  logic                     frm_rtr,
   input  logic [ID_W-1:0]          frm_id,
   input  logic [DLC_W-1:0]         frm_dlc,
   input  logic [BYTE_W-1:0]        frm_d0,
   input  logic [BYTE_W-1:0]        frm_d1,
   input  logic [NBYTES*BYTE_W-1:0] acc_code,
   input  logic [NBYTES*BYTE_W-1:0] acc_mask,
   input  logic                     single_mode,
   output logic                     acc_valid,
   output logic                     acc_ok
);
   import can_filt_pkg::*;

   if (BYTE_W != 8) begin : g_bad_byte
      $error("can_accept_filter: BYTE_W must be 8");
   end
   if (NBYTES != 4) begin : g_bad_nbytes
      $error("can_accept_filter: NBYTES must be 4");
   end
   if (ID_W != NBYTES*BYTE_W - 3) begin : g_bad_id
      $error("can_accept_filter: ID_W must leave 3 spare bits in the last byte");
   end
   if (SID_W != BYTE_W + 3) begin : g_bad_sid
      $error("can_accept_filter: SID_W must span one byte plus 3 bits");
   end
   if (DLC_W < 2) begin : g_bad_dlc
      $error("can_accept_filter: DLC_W too small");
   end

   logic       single_hit, dual_hit, decision;
   filt_mode_e mode_sel;

   can_filt_single #(
      .BYTE_W(BYTE_W), .NBYTES(NBYTES), .ID_W(ID_W), .SID_W(SID_W), .DLC_W(DLC_W)
   ) u_single (
      .ext(frm_ext), .rtr(frm_rtr), .id(frm_id), .dlc(frm_dlc),
      .d0(frm_d0), .d1(frm_d1), .code(acc_code), .mask(acc_mask),
      .hit(single_hit));

   can_filt_dual #(
      .BYTE_W(BYTE_W), .NBYTES(NBYTES), .ID_W(ID_W), .SID_W(SID_W)
   ) u_dual (
      .ext(frm_ext), .rtr(frm_rtr), .id(frm_id), .d0(frm_d0),
      .code(acc_code), .mask(acc_mask), .hit(dual_hit));

   assign mode_sel = filt_mode_e'(single_mode);
   assign decision = (mode_sel == FILT_SINGLE) ? single_hit : dual_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_valid <= 1'b0;
         acc_ok    <= 1'b0;
      end else begin
         acc_valid <= frm_valid;
         acc_ok    <= frm_valid & decision;
      end
   end
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned NBYTES = 4,
   parameter int unsigned ID_W   = 29,
   parameter int unsigned SID_W  = 11,
   parameter int unsigned DLC_W  = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     frm_valid,
   input logic                     frm_ext,
   input logic                     frm_rtr,
   input logic [ID_W-1:0]          frm_id,
   input logic [DLC_W-1:0]         frm_dlc,
   input logic [BYTE_W-1:0]        frm_d0,
   input logic [BYTE_W-1:0]        frm_d1,
   input logic [NBYTES*BYTE_W-1:0] acc_code,
   input logic [NBYTES*BYTE_W-1:0] acc_mask,
   input logic                     single_mode,
   input logic                     acc_valid,
   input logic                     acc_ok
);
   localparam int unsigned HALF_W = 2 * BYTE_W;

   p_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> acc_valid);

   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> !acc_valid);

   p_okvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ok |-> acc_valid);

   p_allpass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && (&acc_mask)) |=> acc_ok);

   p_dual_ext_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && frm_ext && !single_mode && (&acc_mask[HALF_W-1:0])) |=> acc_ok);

   p_single_rtr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && single_mode && !frm_ext && frm_rtr
       && (&acc_mask[BYTE_W-1:0]) && (&acc_mask[2*BYTE_W-1 -: 4])) |=> acc_ok);

   always_comb begin
      if (!rst_n) begin
         a_reset_r10: assert (!acc_valid && !acc_ok);
      end
   end
endmodule

bind can_accept_filter can_accept_filter_chk #(
   .BYTE_W(BYTE_W), .NBYTES(NBYTES), .ID_W(ID_W), .SID_W(SID_W), .DLC_W(DLC_W)
) u_chk (.*);

// File: tb/tb_can_accept_filter.sv
module tb_can_accept_filter;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_valid = 1'b0;
   logic        frm_ext = 1'b0;
   logic        frm_rtr = 1'b0;
   logic [28:0] frm_id = '0;
   logic [3:0]  frm_dlc = '0;
   logic [7:0]  frm_d0 = '0;
   logic [7:0]  frm_d1 = '0;
   logic [31:0] acc_code = '0;
   logic [31:0] acc_mask = '0;
   logic        single_mode = 1'b0;
   logic        acc_valid;
   logic        acc_ok;

   int    n_vec = 0;
   int    n_bad = 0;
   bit    have_pend = 0;
   bit    pend_v, pend_ok;
   string pend_tag;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_accept_filter dut (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ext(frm_ext),
      .frm_rtr(frm_rtr), .frm_id(frm_id), .frm_dlc(frm_dlc), .frm_d0(frm_d0),
      .frm_d1(frm_d1), .acc_code(acc_code), .acc_mask(acc_mask),
      .single_mode(single_mode), .acc_valid(acc_valid), .acc_ok(acc_ok));

   // behavioural reference for the keep/drop decision
   function automatic bit model(bit sgl, bit ext, bit rtr, int unsigned id,
                                int unsigned dlc, int unsigned d0, int unsigned d1,
                                logic [31:0] c, logic [31:0] m);
      int unsigned cb[4];
      int unsigned mb[4];
      int unsigned e, k;
      for (int i = 0; i < 4; i++) begin
         cb[i] = (c >> (8*i)) & 8'hFF;
         mb[i] = (m >> (8*i)) & 8'hFF;
      end
      if (sgl) begin
         if (ext) begin
            e = (cb[0] << 21) | (cb[1] << 13) | (cb[2] << 5) | (cb[3] >> 3);
            k = (mb[0] << 21) | (mb[1] << 13) | (mb[2] << 5) | (mb[3] >> 3);
            if (((id ^ e) & ~k & 32'h1FFF_FFFF) != 0) return 0;
            if ((mb[3] & 4) == 0 && rtr != ((cb[3] >> 2) & 1)) return 0;
            return 1;
         end
         e = (cb[0] << 3) | (cb[1] >> 5);
         k = (mb[0] << 3) | (mb[1] >> 5);
         if (((id ^ e) & ~k & 32'h7FF) != 0) return 0;
         if ((mb[1] & 16) == 0 && rtr != ((cb[1] >> 4) & 1)) return 0;
         if (rtr || dlc == 0) return 1;
         if (((d0 ^ cb[2]) & ~mb[2] & 8'hFF) != 0) return 0;
         if (dlc == 1) return 1;
         return (((d1 ^ cb[3]) & ~mb[3] & 8'hFF) == 0);
      end
      for (int f = 0; f < 2; f++) begin
         int unsigned a = cb[2*f], b = cb[2*f+1], ma = mb[2*f], mbb = mb[2*f+1];
         if (ext) begin
            e = (a << 8) | b;
            k = (ma << 8) | mbb;
            if ((((id >> 13) ^ e) & ~k & 32'hFFFF) == 0) return 1;
         end else begin
            bit ok;
            e = (a << 3) | (b >> 5);
            k = (ma << 3) | (mbb >> 5);
            ok = (((id ^ e) & ~k & 32'h7FF) == 0);
            if ((mbb & 16) == 0 && rtr != ((b >> 4) & 1)) ok = 0;
            if (f == 0) begin
               int unsigned de, dk;
               de = ((cb[1] & 15) << 4) | (cb[3] & 15);
               dk = ((mb[1] & 15) << 4) | (mb[3] & 15);
               if (((d0 ^ de) & ~dk & 8'hFF) != 0) ok = 0;
            end
            if (ok) return 1;
         end
      end
      return 0;
   endfunction

   task automatic compare_pending();
      if (have_pend) begin
         n_vec++;
         if (acc_valid !== pend_v || acc_ok !== pend_ok) begin
            n_bad++;
            $display("FAIL %s: acc_valid/acc_ok = %b/%b, expected %b/%b",
                     pend_tag, acc_valid, acc_ok, pend_v, pend_ok);
         end
      end
   endtask

   // forced: -1 = take the model's decision, 0/1 = explicit expectation
   task automatic apply(string tag, bit vld, bit sgl, bit ext, bit rtr,
                        logic [28:0] id, logic [3:0] dlc, logic [7:0] d0,
                        logic [7:0] d1, logic [31:0] c, logic [31:0] m, int forced);
      @(negedge clk);
      compare_pending();
      frm_valid = vld; single_mode = sgl; frm_ext = ext; frm_rtr = rtr;
      frm_id = id; frm_dlc = dlc; frm_d0 = d0; frm_d1 = d1;
      acc_code = c; acc_mask = m;
      pend_v   = vld;
      pend_ok  = vld && ((forced >= 0) ? (forced != 0)
                         : model(sgl, ext, rtr, id, dlc, d0, d1, c, m));
      pend_tag = tag;
      have_pend = 1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      n_vec++;
      if (acc_valid !== 1'b0 || acc_ok !== 1'b0) begin
         n_bad++;
         $display("FAIL R10: reset outputs %b/%b, expected 0/0", acc_valid, acc_ok);
      end
      rst_n = 1'b1;

      // R8: no strobe, fields that would match
      apply("R8", 0, 1, 0, 0, 29'h52D, 4'd0, 8'h00, 8'h00, 32'h993CA0A5, 32'h00000F00, -1);

      // R2: single extended
      apply("R2", 1, 1, 1, 0, 29'h02468ACF, 4'd8, 8'h00, 8'h00, 32'h78563412, 32'h03000000, 1);
      apply("R2", 1, 1, 1, 0, 29'h02468ACE, 4'd8, 8'h00, 8'h00, 32'h78563412, 32'h03000000, 0);
      apply("R2", 1, 1, 1, 1, 29'h02468ACF, 4'd0, 8'h00, 8'h00, 32'h78563412, 32'h03000000, 0);
      apply("R2", 1, 1, 1, 1, 29'h02468ACF, 4'd0, 8'h00, 8'h00, 32'h78563412, 32'h07000000, 1);

      // R3 / R4: single standard
      apply("R3", 1, 1, 0, 0, 29'h12D,     4'd0, 8'h00, 8'h00, 32'h993CA0A5, 32'h00000F00, 0);
      apply("R3", 1, 1, 0, 1, 29'h52D,     4'd0, 8'h00, 8'h00, 32'h993CA0A5, 32'h00000F00, 0);
      apply("R4", 1, 1, 0, 0, 29'h52D,     4'd0, 8'h00, 8'h00, 32'h993CA0A5, 32'h00000F00, 1);
      apply("R4", 1, 1, 0, 0, 29'h52D,     4'd1, 8'h3C, 8'h00, 32'h993CA0A5, 32'h00000F00, 1);
      apply("R4", 1, 1, 0, 0, 29'h52D,     4'd1, 8'h3D, 8'h99, 32'h993CA0A5, 32'h00000F00, 0);
      apply("R4", 1, 1, 0, 0, 29'h52D,     4'd2, 8'h3C, 8'h99, 32'h993CA0A5, 32'h00000F00, 1);
      apply("R4", 1, 1, 0, 0, 29'h52D,     4'd2, 8'h3C, 8'h98, 32'h993CA0A5, 32'h00000F00, 0);
      apply("R4", 1, 1, 0, 1, 29'h52D,     4'd4, 8'hFF, 8'hFF, 32'h993CA0A5, 32'h00001F00, 1);

      // R1: same frame, layouts disagree
      apply("R1", 1, 1, 0, 0, 29'h52D,     4'd1, 8'h39, 8'h00, 32'h993CA0A5, 32'h00000F00, 0);
      apply("R1", 1, 0, 0, 0, 29'h52D,     4'd1, 8'h39, 8'h00, 32'h993CA0A5, 32'h00000F00, 1);

      // R5: dual extended
      apply("R5", 1, 0, 1, 1, 29'h06689ABC, 4'd0, 8'h00, 8'h00, 32'h44332211, 32'h0, 1);
      apply("R5", 1, 0, 1, 0, 29'h02244123, 4'd3, 8'h55, 8'h00, 32'h44332211, 32'h0, 1);
      apply("R5", 1, 0, 1, 0, 29'h02264000, 4'd3, 8'h55, 8'h00, 32'h44332211, 32'h0, 0);

      // R6 / R7: dual standard
      apply("R7", 1, 0, 0, 0, 29'h283, 4'd1, 8'h69, 8'h00, 32'hE97F6650, 32'h0, 1);
      apply("R7", 1, 0, 0, 0, 29'h283, 4'd1, 8'h68, 8'h00, 32'hE97F6650, 32'h0, 0);
      apply("R7", 1, 0, 0, 0, 29'h283, 4'd0, 8'h68, 8'h00, 32'hE97F6650, 32'h0, 0);
      apply("R6", 1, 0, 0, 0, 29'h3FF, 4'd0, 8'h00, 8'h00, 32'hE97F6650, 32'h0, 1);
      apply("R6", 1, 0, 0, 1, 29'h3FF, 4'd0, 8'h00, 8'h00, 32'hE97F6650, 32'h0, 0);
      apply("R6", 1, 0, 0, 0, 29'h284, 4'd1, 8'h69, 8'h00, 32'hE97F6650, 32'h0, 0);

      // R9: all masks set, both layouts, back to back
      for (int i = 0; i < 40; i++) begin
         apply("R9", 1, i[0], i[1], i[2], 29'($urandom), 4'($urandom_range(0, 8)),
               8'($urandom), 8'($urandom), $urandom, 32'hFFFFFFFF, 1);
      end

      // R8 plus all layouts: mixed random traffic, strobe toggling
      for (int i = 0; i < 600; i++) begin
         logic [31:0] c, m;
         logic [28:0] id;
         bit          ext;
         c   = $urandom;
         m   = $urandom | $urandom;
         ext = $urandom_range(0, 1) != 0;
         id  = 29'($urandom);
         if ($urandom_range(0, 1) != 0)
            id = ext ? {c[7:0], c[15:8], c[23:16], c[31:27]}
                     : {18'd0, c[7:0], c[15:13]};
         apply((i % 2 == 0) ? "R8" : "R1", $urandom_range(0, 3) != 0,
               $urandom_range(0, 1) != 0, ext, $urandom_range(0, 1) != 0, id,
               4'($urandom_range(0, 8)), 8'($urandom), 8'($urandom), c, m, -1);
      end

      apply("R8", 0, 0, 0, 0, 29'h0, 4'd0, 8'h00, 8'h00, 32'h0, 32'hFFFFFFFF, -1);
      @(negedge clk);
      compare_pending();
      have_pend = 0;

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule